// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each bus cycle on a 24-bit address bus with a 16-bit data path into up to twelve active-low select lines. Select 0 is the boot select and comes out of reset already mapped at the bottom of memory. Selects 1 to 11 are general purpose. Each select has three things written through a register write port: a base word (block address and block size), an option word (byte lane, access direction and privilege space), and a 2-bit pin-role field. A select asserts only when all of the following hold: the address falls inside its block, the byte strobes reach its lane, the direction is allowed, the function code falls in its space, and its pin is assigned as a chip select.

The select lines come from a two-state cycle tracker. In state S_IDLE no select is driven. The transition IDLE_TO_HOLD is taken on the first clock edge that sees the bus strobe high. On that edge the decoded hit vector is captured into the output register. In state S_HOLD the captured vector is held unchanged for as long as the strobe stays high (transition HOLD_STAY), even if the address lines move. The transition HOLD_TO_IDLE is taken on the first edge that sees the strobe low, and it clears every select. When the strobe is low in S_IDLE the state does not change (transition IDLE_STAY). Overlapping selects are not arbitrated: every select that qualifies asserts.

Register map (reg_addr): 0 to 11 hold the base word of select 0 to 11. 16 to 27 hold the option word of select 0 to 11. 32 holds the pin-role word for selects 0 to 7. 33 holds the pin-role word for selects 8 to 11. In the pin-role words, select i uses bits [2(i mod 8)+1 : 2(i mod 8)].

Top module: `cs_decoder`

## Requirements
- R1: Base word bits [15:3] give address bits A23..A11 of the block, and bits [2:0] give the size code. Codes 0..7 select 2k, 8k, 16k, 64k, 128k, 256k, 512k and 1M. Only address bits A23 down to A11, A13, A14, A16, A17, A18, A19 and A20 respectively are compared.
- R2: Option bits [14:13] give the byte lane. 01 means lower (needs bus_lds), 10 means upper (needs bus_uds), and 11 means both (needs either strobe).
- R3: Option bits [12:11] give the direction. 01 means read only (bus_read=1), 10 means write only (bus_read=0), and 11 means either direction.
- R4: Option bits [5:4] give the space. 00 means CPU space (bus_fc=111), 01 means user (bus_fc[2]=0), 10 means supervisor (bus_fc[2]=1 and bus_fc not 111), and 11 means user or supervisor (bus_fc not 111).
- R5: A select asserts only if its pin-role field is 10 (chip select, 8-bit port) or 11 (chip select, 16-bit port). Roles 00 (discrete) and 01 (alternate) keep it high.
- R6: A select whose lane code is 00 or whose direction code is 00 never asserts.
- R7: When several selects qualify in one cycle, all of them assert together.
- R8: The hit vector is captured on the first edge with bus_strobe high, appears on cs_n after that edge, and holds unchanged while the strobe stays high.
- R9: All cs_n lines are high after the first edge that sees bus_strobe low, and they stay high while no strobe is present.
- R10: After reset, select 0 has base 0x0003, option lane 11, direction 11 and space 11, and pin role 11. All other selects have base 0, option 0 and pin role 00.
- R11: A write with reg_we high updates the addressed word on that edge, and the next captured cycle uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Register write data |
| bus_strobe | input | 1 | Address strobe, high while a bus cycle is valid |
| bus_addr | input | 24 | Bus address |
| bus_read | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_uds | input | 1 | Upper byte strobe, active high |
| bus_lds | input | 1 | Lower byte strobe, active high |
| bus_fc | input | 3 | Function code of the cycle |
| cs_n | output | 12 | Active-low select lines, bit i = select i |

## Verification
The hold assertion takes for granted that a bus cycle is marked by the strobe alone. Within one strobe, the address and qualifiers may change without effect. The stimulus therefore always separates bus cycles with at least one edge where the strobe is low. The write-capture assertion takes for granted that reg_we is a single clean pulse with a stable address. The bench writes registers only at the falling edge and drops reg_we after one edge, and it never writes while it is sampling a bus cycle for a check.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } cyc_state_t;

    localparam logic [1:0] LANE_LOWER = 2'b01;
    localparam logic [1:0] LANE_UPPER = 2'b10;
    localparam logic [1:0] LANE_BOTH  = 2'b11;
    localparam logic [1:0] DIR_READ   = 2'b01;
    localparam logic [1:0] DIR_WRITE  = 2'b10;
    localparam logic [1:0] DIR_ANY    = 2'b11;
    localparam logic [1:0] SPC_CPU    = 2'b00;
    localparam logic [1:0] SPC_USER   = 2'b01;
    localparam logic [1:0] SPC_SUPER  = 2'b10;
    localparam logic [1:0] SPC_ANY    = 2'b11;

    function automatic int unsigned size_low_bit(input logic [2:0] code);
        case (code)
            3'd0:    return 11;
            3'd1:    return 13;
            3'd2:    return 14;
            3'd3:    return 16;
            3'd4:    return 17;
            3'd5:    return 18;
            3'd6:    return 19;
            default: return 20;
        endcase
    endfunction
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile #(
    parameter int NUM_CS = 12,
    parameter int DATA_W = 16,
    parameter int REG_AW = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [REG_AW-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_CS-1:0][DATA_W-1:0]  base_o,
    output logic [NUM_CS-1:0][1:0]         lane_o,
    output logic [NUM_CS-1:0][1:0]         dir_o,
    output logic [NUM_CS-1:0][1:0]         space_o,
    output logic [NUM_CS-1:0][1:0]         role_o
);
    localparam int PIN_W    = 2 * NUM_CS;
    localparam int BASE_OFS = 0;
    localparam int OPT_OFS  = 16;
    localparam int PIN_OFS  = 32;
    localparam logic [DATA_W-1:0] BOOT_BASE_RST = DATA_W'(16'h0003);

    logic [NUM_CS-1:0][DATA_W-1:0] base_q;
    logic [NUM_CS-1:0][5:0]        opt_q;
    logic [PIN_W-1:0]              pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                base_q[i] <= (i == 0) ? BOOT_BASE_RST : '0;
                opt_q[i]  <= (i == 0) ? 6'b111111 : 6'b000000;
            end
            pin_q <= PIN_W'(2'b11);
        end else if (we) begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (addr == REG_AW'(BASE_OFS + i)) base_q[i] <= wdata;
                if (addr == REG_AW'(OPT_OFS + i))  opt_q[i]  <= {wdata[14:11], wdata[5:4]};
            end
            for (int b = 0; b < PIN_W; b++) begin
                if (addr == REG_AW'(PIN_OFS + b / 16)) pin_q[b] <= wdata[b % 16];
            end
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_fields
        assign base_o[g]  = base_q[g];
        assign lane_o[g]  = opt_q[g][5:4];
        assign dir_o[g]   = opt_q[g][3:2];
        assign space_o[g] = opt_q[g][1:0];
        assign role_o[g]  = pin_q[2*g +: 2];
    end

    // R11
    base_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == REG_AW'(BASE_OFS)) |=> (base_o[0] == $past(wdata)));
    // R11
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == REG_AW'(OPT_OFS)) |=> (lane_o[0] == $past(wdata[14:13])));
endmodule

// File: rtl/cs_match.sv
module cs_match
    import cs_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int BASE_LSB = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              uds,
    input  logic              lds,
    input  logic [2:0]        fc,
    input  logic [DATA_W-1:0] base,
    input  logic [1:0]        lane,
    input  logic [1:0]        dir,
    input  logic [1:0]        space,
    input  logic [1:0]        role,
    output logic              hit
);
    localparam int CMP_W = ADDR_W - BASE_LSB;

    logic [ADDR_W-1:0] blk_addr;
    logic [ADDR_W-1:0] cmp_mask;
    logic addr_ok, lane_ok, dir_ok, space_ok, cpu_cyc;

    assign blk_addr = {base[DATA_W-1 -: CMP_W], {BASE_LSB{1'b0}}};
    assign cpu_cyc  = (fc == 3'b111);

    always_comb begin
        for (int k = 0; k < ADDR_W; k++) begin
            cmp_mask[k] = (k >= int'(size_low_bit(base[2:0])));
        end
        addr_ok = (((addr ^ blk_addr) & cmp_mask) == '0);

        unique case (lane)
            LANE_LOWER: lane_ok = lds;
            LANE_UPPER: lane_ok = uds;
            LANE_BOTH:  lane_ok = uds | lds;
            default:    lane_ok = 1'b0;
        endcase

        unique case (dir)
            DIR_READ:  dir_ok = rd;
            DIR_WRITE: dir_ok = ~rd;
            DIR_ANY:   dir_ok = 1'b1;
            default:   dir_ok = 1'b0;
        endcase

        unique case (space)
            SPC_CPU:   space_ok = cpu_cyc;
            SPC_USER:  space_ok = ~fc[2];
            SPC_SUPER: space_ok = fc[2] & ~cpu_cyc;
            default:   space_ok = ~cpu_cyc;
        endcase
    end

    assign hit = addr_ok & lane_ok & dir_ok & space_ok & role[1];

    // R6
    qual_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (lane != 2'b00 && dir != 2'b00));
    // R5
    pin_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> role[1]);
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_pkg::*;
#(
    parameter int NUM_CS = 12,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int REG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_read,
    input  logic              bus_uds,
    input  logic              bus_lds,
    input  logic [2:0]        bus_fc,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int BASE_LSB = 11;

    logic [NUM_CS-1:0][DATA_W-1:0] base_w;
    logic [NUM_CS-1:0][1:0]        lane_w, dir_w, space_w, role_w;
    logic [NUM_CS-1:0]             hit_w;
    logic [NUM_CS-1:0]             hit_q;
    cyc_state_t                    state_q, state_d;

    cs_regfile #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .base_o(base_w), .lane_o(lane_w), .dir_o(dir_w), .space_o(space_w), .role_o(role_w)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        cs_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) u_match (
            .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_read),
            .uds(bus_uds), .lds(bus_lds), .fc(bus_fc),
            .base(base_w[g]), .lane(lane_w[g]), .dir(dir_w[g]),
            .space(space_w[g]), .role(role_w[g]), .hit(hit_w[g])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (bus_strobe)  state_d = S_HOLD;
            S_HOLD:  if (!bus_strobe) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:  if (bus_strobe)  hit_q <= hit_w;
                S_HOLD:  if (!bus_strobe) hit_q <= '0;
                default: hit_q <= '0;
            endcase
        end
    end

    assign cs_n = ~hit_q;

    // R9
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_strobe) |=> (cs_n == '1));
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && bus_strobe) |=> $stable(cs_n));
    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && bus_strobe) |=> (cs_n == ~$past(hit_w)));
endmodule

// File: tb/cs_decoder_bench.sv
module cs_decoder_bench;
    localparam int N = 12;

    typedef struct packed {
        logic [23:0]  addr;
        logic         rd;
        logic         uds;
        logic         lds;
        logic [2:0]   fc;
        logic [N-1:0] hit;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{24'h001234, 1'b1, 1'b1, 1'b1, 3'b101, 12'h001, 8'd1},  // R1 boot 64k
        '{24'h00FFFF, 1'b1, 1'b1, 1'b1, 3'b001, 12'h001, 8'd1},  // R1 top of block
        '{24'h010000, 1'b1, 1'b1, 1'b1, 3'b101, 12'h000, 8'd1},  // R1 just outside
        '{24'h100010, 1'b0, 1'b0, 1'b1, 3'b001, 12'h002, 8'd2},  // R2 lower lane
        '{24'h11FFFE, 1'b0, 1'b1, 1'b0, 3'b101, 12'h004, 8'd2},  // R2 upper lane
        '{24'h100000, 1'b0, 1'b1, 1'b1, 3'b001, 12'h002, 8'd4},  // R4 user only
        '{24'h100000, 1'b1, 1'b0, 1'b1, 3'b001, 12'h000, 8'd3},  // R3 write only refuses read
        '{24'h100000, 1'b0, 1'b1, 1'b1, 3'b101, 12'h004, 8'd4},  // R4 supervisor
        '{24'h120000, 1'b0, 1'b1, 1'b1, 3'b101, 12'h000, 8'd1},  // R1 128k edge
        '{24'h0207FF, 1'b1, 1'b1, 1'b1, 3'b111, 12'h008, 8'd5},  // R5 R6 cpu 2k
        '{24'h020800, 1'b1, 1'b1, 1'b1, 3'b111, 12'h000, 8'd1},  // R1 2k edge
        '{24'h020000, 1'b1, 1'b1, 1'b1, 3'b101, 12'h000, 8'd4},  // R4 cpu only
        '{24'hF12345, 1'b1, 1'b1, 1'b1, 3'b101, 12'h040, 8'd6},  // R6 dir 00 never
        '{24'hFFFFFF, 1'b0, 1'b1, 1'b0, 3'b001, 12'h040, 8'd1},  // R1 1M block
        '{24'hE00000, 1'b1, 1'b1, 1'b1, 3'b101, 12'h000, 8'd1}   // R1 no block
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic          bus_strobe = 1'b0;
    logic [23:0]   bus_addr = '0;
    logic          bus_read = 1'b1;
    logic          bus_uds = 1'b0;
    logic          bus_lds = 1'b0;
    logic [2:0]    bus_fc = 3'b101;
    logic [N-1:0]  cs_n;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cs_decoder u_cs_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
        .bus_read(bus_read), .bus_uds(bus_uds), .bus_lds(bus_lds),
        .bus_fc(bus_fc), .cs_n(cs_n)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic start_cycle(input logic [23:0] a, input logic rd, input logic u,
                               input logic l, input logic [2:0] fc);
        bus_addr = a; bus_read = rd; bus_uds = u; bus_lds = l; bus_fc = fc;
        bus_strobe = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic end_cycle();
        bus_strobe = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", cs_n, '1);

        // R10: boot select live from reset, others silent at base 0
        start_cycle(24'h000010, 1'b1, 1'b1, 1'b1, 3'b101);
        check("R10 boot reset map", cs_n, ~12'h001);
        end_cycle();
        check("R9 release", cs_n, '1);

        // R11 program selects 1..7
        wr(6'd1, 16'h1004);  wr(6'd17, 16'h3010);
        wr(6'd2, 16'h1004);  wr(6'd18, 16'h5820);
        wr(6'd3, 16'h0200);  wr(6'd19, 16'h6800);
        wr(6'd4, 16'h0200);  wr(6'd20, 16'h6800);
        wr(6'd5, 16'h0200);  wr(6'd21, 16'h1830);
        wr(6'd6, 16'hF007);  wr(6'd22, 16'h7830);
        wr(6'd7, 16'hF007);  wr(6'd23, 16'h6030);
        wr(6'd32, 16'hFDFB);

        for (int i = 0; i < NV; i++) begin
            start_cycle(VEC[i].addr, VEC[i].rd, VEC[i].uds, VEC[i].lds, VEC[i].fc);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), cs_n, ~VEC[i].hit);
            end_cycle();
            check($sformatf("R9 release after vector %0d", i), cs_n, '1);
        end

        // R7 overlapping select 8 on the boot block
        wr(6'd8, 16'h0003); wr(6'd24, 16'h7830); wr(6'd33, 16'h0003);
        start_cycle(24'h000100, 1'b1, 1'b1, 1'b1, 3'b101);
        check("R7 both selects", cs_n, ~12'h101);
        // R8 address moves inside the strobe: selects hold
        bus_addr = 24'hE00000;
        @(posedge clk); @(negedge clk);
        check("R8 hold through cycle", cs_n, ~12'h101);
        end_cycle();
        check("R9 release after hold", cs_n, '1);

        // R9 matching address without strobe
        bus_addr = 24'h000100;
        @(posedge clk); @(negedge clk);
        check("R9 no strobe", cs_n, '1);

        // R11 move boot block to 128k at 0x0E0000
        wr(6'd0, 16'h0E04);
        start_cycle(24'h0E1000, 1'b1, 1'b1, 1'b1, 3'b101);
        check("R11 boot moved", cs_n, ~12'h001);
        end_cycle();
        start_cycle(24'h000100, 1'b1, 1'b1, 1'b1, 3'b101);
        check("R11 old boot range gone", cs_n, ~12'h100);
        end_cycle();

        // R5 switch select 8 to discrete role
        wr(6'd33, 16'h0000);
        start_cycle(24'h000100, 1'b1, 1'b1, 1'b1, 3'b101);
        check("R5 discrete role", cs_n, '1);
        end_cycle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule